// File: doc/BRIEF.md
# Four-Pin Bidirectional Port Controller with Pull-Ups

This block controls a small four-pin port through a simple register bus. Three of the pins (bit positions 3, 1 and 0) are general-purpose and bidirectional. Each one has a direction bit and a latch bit. Together these two bits decide whether the pin drives a value, floats, or floats with its pull-up turned on. The fourth pin (bit position 2) is always an output. It follows an external modulator signal, and no register affects it.

For every pin the controller produces three pad signals: an output enable, an output value and a pull-up enable. Software can read the two control registers back, and it can also read a sample address. The sample address returns the pin levels after they pass through a two-stage synchronizer. Reset clears both registers asynchronously, so the general pins go to high impedance even when no clock is running.

Top module: `gpio4_port`

## Requirements
- R1: An active-low `rst_n` clears the direction and latch registers at once, without waiting for a clock edge. While reset is held and after it is released, `pad_oe` is 4'b0100 and `pad_pu` is 4'b0000.
- R2: A write to address 0x1A stores bits 3, 1 and 0 of the data as direction bits. For those pins, `pad_oe` equals the stored direction bit, where 1 means output.
- R3: When a general pin's direction bit is 1, its `pad_out` bit equals its latch bit and its `pad_pu` bit is 0, whatever the latch holds.
- R4: When a general pin's direction bit is 0, its `pad_oe` and `pad_out` bits are 0. Its `pad_pu` bit equals its latch bit, so the pull-up is on only when the latch bit is 1.
- R5: A write to address 0x1B stores bits 3, 1 and 0 as latch bits. Reading 0x1B or 0x1A returns the stored bits in positions 3, 1 and 0. Bits 7 to 4 and bit 2 are ignored on write and read as 0.
- R6: Reading address 0x19 returns each general pin's input level in bits 3, 1 and 0, two rising edges after the level is applied, and the other bits read as 0. Writes to 0x19 change no register.
- R7: Pin 2 always has `pad_oe[2]`=1 and `pad_out[2]`=`mod_in` (combinational) and `pad_pu[2]`=0. Direction and latch writes do not change this.
- R8: A write takes effect on the rising edge where `bus_wr` is 1, so `bus_rdata` shows the old value during the write cycle. Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 4 | Levels seen at the pads |
| mod_in | input | 1 | Modulator signal for pin 2 |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin driven value |
| pad_pu | output | 4 | Per-pin pull-up enable |

## Verification
A write strobe and a read of the same register can land in one cycle, because the bus carries only one address. The bench holds `bus_wr` high at the latch address and samples `bus_rdata` before the edge, where it expects the old contents. It samples again after the edge and expects the new contents. A second overlap happens when a pin level changes while the sample address is being read: the bench checks that the read still returns the old level after one edge and the new level only after the second edge.

// File: rtl/gpio4_port.sv
module gpio4_port #(
  parameter int NPINS = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] PIN_ADDR = 8'h19,
  parameter logic [AW-1:0] DIR_ADDR = 8'h1A,
  parameter logic [AW-1:0] LAT_ADDR = 8'h1B,
  parameter logic [NPINS-1:0] GP_MASK = 4'b1011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic             mod_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pu
);
  localparam logic [NPINS-1:0] FIXED_OUT = ~GP_MASK;
  localparam logic [DW-1:0]    RD_MASK = {{(DW-NPINS){1'b0}}, GP_MASK};

  logic [NPINS-1:0] dir_q, lat_q, sync1_q, sync2_q;
  logic wr_dir, wr_lat;

  assign wr_dir = bus_wr && (bus_addr == DIR_ADDR);
  assign wr_lat = bus_wr && (bus_addr == LAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata[NPINS-1:0] & GP_MASK;
      if (wr_lat) lat_q <= bus_wdata[NPINS-1:0] & GP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in & GP_MASK;
      sync2_q <= sync1_q;
    end
  end

  assign pad_oe  = dir_q | FIXED_OUT;
  assign pad_out = (dir_q & lat_q) | (FIXED_OUT & {NPINS{mod_in}});
  assign pad_pu  = ~dir_q & lat_q & GP_MASK;

  always_comb begin
    case (bus_addr)
      PIN_ADDR: bus_rdata = {{(DW-NPINS){1'b0}}, sync2_q};
      DIR_ADDR: bus_rdata = {{(DW-NPINS){1'b0}}, dir_q};
      LAT_ADDR: bus_rdata = {{(DW-NPINS){1'b0}}, lat_q};
      default:  bus_rdata = '0;
    endcase
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_ADDR) |=> (pad_oe == (($past(bus_wdata[NPINS-1:0]) & GP_MASK) | FIXED_OUT)));

  p_lat_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == LAT_ADDR) |=> (lat_q == ($past(bus_wdata[NPINS-1:0]) & GP_MASK)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == DIR_ADDR || bus_addr == LAT_ADDR)) |=> ($stable(dir_q) && $stable(lat_q)));

  p_pu_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  p_pin_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == PIN_ADDR) |-> ((bus_rdata & ~RD_MASK) == '0));

  p_fixed_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & FIXED_OUT) == FIXED_OUT) && ((pad_pu & FIXED_OUT) == '0));
endmodule

// File: tb/gpio4_port_tb.sv
module gpio4_port_tb;
  logic clk = 0, rst_n = 0, bus_wr = 0, mod_in = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [3:0] pin_in = 0, pad_oe, pad_out, pad_pu;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {int kind; logic [7:0] exp; string tag;} item_t;
  item_t q[$];
  event ev_chk;

  always #10 clk = ~clk;

  gpio4_port u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .mod_in(mod_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu));

  always begin
    @(ev_chk);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {4'h0, pad_oe};
        2: act = {4'h0, pad_out};
        default: act = {4'h0, pad_pu};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->ev_chk;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; #1;
    push(0, exp, tag);
  endtask

  task automatic pads(input logic [3:0] oe, input logic [3:0] o, input logic [3:0] pu, input string tag);
    push(1, {4'h0, oe}, tag);
    push(2, {4'h0, o}, tag);
    push(3, {4'h0, pu}, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    pads(4'b0100, 4'b0000, 4'b0000, "R1 pads in reset");
    rst_n = 1;
    @(negedge clk);
    rd(8'h1A, 8'h00, "R1 dir after reset");
    rd(8'h1B, 8'h00, "R1 latch after reset");
    rd(8'h19, 8'h00, "R1 pin sample after reset");
    pads(4'b0100, 4'b0000, 4'b0000, "R1 pads after reset");

    wr(8'h1A, 8'hFF);
    rd(8'h1A, 8'h0B, "R5 dir readback masked");
    pads(4'b1111, 4'b0000, 4'b0000, "R2 all outputs latch 0");
    wr(8'h1B, 8'hFF);
    rd(8'h1B, 8'h0B, "R5 latch readback masked");
    pads(4'b1111, 4'b1011, 4'b0000, "R3 outputs drive 1 no pull-up");

    wr(8'h1A, 8'h00);
    mod_in = 1; #1;
    pads(4'b0100, 4'b0100, 4'b1011, "R4 inputs with pull-ups, R7 mod high");
    wr(8'h1B, 8'h02);
    pads(4'b0100, 4'b0100, 4'b0010, "R4 pull-up only where latch set");

    wr(8'h1A, 8'h01);
    wr(8'h1B, 8'h03);
    mod_in = 0; #1;
    pads(4'b0101, 4'b0001, 4'b0010, "R3 R4 mixed pins, R7 mod low");

    wr(8'h1A, 8'h04);
    rd(8'h1A, 8'h00, "R5 dir bit2 ignored");
    mod_in = 1; #1;
    pads(4'b0100, 4'b0100, 4'b0011, "R7 pin2 independent of registers");

    @(negedge clk);
    pin_in = 4'b1111;
    bus_addr = 8'h19;
    @(negedge clk);
    rd(8'h19, 8'h00, "R6 one edge not yet visible");
    @(negedge clk);
    rd(8'h19, 8'h0B, "R6 two edges visible, bit2 zero");
    pin_in = 4'b0100;
    @(negedge clk); @(negedge clk);
    rd(8'h19, 8'h00, "R6 pin2 level never shown");

    wr(8'h19, 8'hFF);
    rd(8'h1A, 8'h00, "R6 write to sample addr ignored dir");
    rd(8'h1B, 8'h03, "R6 write to sample addr ignored latch");
    wr(8'h00, 8'hFF);
    rd(8'h00, 8'h00, "R8 unmapped read zero");
    rd(8'h1B, 8'h03, "R8 unmapped write ignored");

    @(negedge clk);
    bus_addr = 8'h1B; bus_wdata = 8'h08; bus_wr = 1; #1;
    push(0, 8'h03, "R8 old value during write cycle");
    @(negedge clk);
    bus_wr = 0; #1;
    push(0, 8'h08, "R8 new value after edge");

    wr(8'h1A, 8'h0B);
    wr(8'h1B, 8'h0B);
    @(posedge clk);
    #5 rst_n = 0; #1;
    pads(4'b0100, {1'b0, mod_in, 2'b00}, 4'b0000, "R1 async reset mid-cycle");
    #20 rst_n = 1;
    @(negedge clk);
    rd(8'h1A, 8'h00, "R1 dir cleared by async reset");
    rd(8'h1B, 8'h00, "R1 latch cleared by async reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule